// File: doc/BRIEF.md
# Data Address Breakpoint Detector

This block watches the data side of a processor pipeline and raises a breakpoint exception request when a load or store touches a watched double-word. It holds a small bank of breakpoint entries. Each entry stores a compare address and three qualifiers: a load enable, a store enable and the translation state that the access must be in. Every data access presents a valid strobe, an effective address, a load/store indication and the current data-translation state. Instruction fetches never reach this port, so they cannot trigger it.

Software programs an entry through a one-word write port. The entry is picked by an index and loaded in a single cycle. The word layout, with LSB-0 numbering, is: bit 0 load enable, bit 1 store enable, bit 2 required translation state, and bits 31..3 the double-word address. The result is registered. One clock after a qualifying access, the block drives a single-cycle request pulse together with a per-entry hit vector. Two entries are provided by default.

Top module: `dab_detect`

## Requirements
- R1: A synchronous reset clears every entry to all zeros, including the load and store enables, so no access hits until an entry is written. While reset is held and in the cycle after it, `brk_req` and `brk_hit` are zero.
- R2: The address compare uses address bits 31..3 only. Bits 2..0 of the access address are ignored, so any byte of the watched double-word hits, and the next double-word does not.
- R3: A load (`acc_is_store`=0) can hit an entry only if that entry's bit 0 (load enable) is set.
- R4: A store (`acc_is_store`=1) can hit an entry only if that entry's bit 1 (store enable) is set.
- R5: An entry hits only if `acc_xlate` equals that entry's bit 2.
- R6: `brk_hit[i]` reports a hit on entry i. If several entries hit, all their bits are set and `brk_req` is a single pulse, the OR of the hit bits.
- R7: The outputs are registered. An access with `acc_valid`=1 at clock edge N is reported in the cycle after edge N, for exactly one cycle. With `acc_valid`=0 the outputs are zero in the following cycle, whatever the address.
- R8: `cfg_we`=1 loads `cfg_wdata` into entry `cfg_sel` at the clock edge. An access presented in the same cycle is judged against the old contents, and later accesses see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_sel | input | SEL_W | Index of the entry to write |
| cfg_wdata | input | ADDR_W | Entry word: [ADDR_W-1:3] address, [2] translation, [1] store enable, [0] load enable |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | ADDR_W | Effective address of the access |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_xlate | input | 1 | Current data-translation state |
| brk_req | output | 1 | Registered breakpoint exception request pulse |
| brk_hit | output | NUM_BP | Registered per-entry hit flags |

## Verification
Directed accesses vary one qualifier at a time against a programmed entry: the byte offset inside the double-word, the neighbouring double-word, load against store, and the translation state. A wrong result therefore points at a single field of the compare. Two entries are also pointed at the same double-word to separate the OR of hits from a priority pick. An entry is rewritten in the same cycle as an access to separate the old contents from the new. A long random phase then draws addresses from a small pool and uses random qualifiers and interleaved writes, and the behavioural model checks every cycle, including idle strobes.

// File: rtl/dab_pkg.sv
package dab_pkg;
  // Bit positions inside an entry word (LSB-0); software depends on these.
  localparam int FLD_RE   = 0;
  localparam int FLD_WE   = 1;
  localparam int FLD_XL   = 2;
  localparam int GRAN_MIN = 3;

  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/dab_bp_bank.sv
module dab_bp_bank #(
  parameter int ADDR_W = 32,
  parameter int GRAN   = 3,
  parameter int NUM_BP = 2,
  parameter int SEL_W  = 1,
  localparam int CMP_W = ADDR_W - GRAN
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [SEL_W-1:0]             cfg_sel,
  input  logic [ADDR_W-1:0]            cfg_wdata,
  output logic [NUM_BP-1:0][CMP_W-1:0] ent_addr,
  output logic [NUM_BP-1:0]            ent_re,
  output logic [NUM_BP-1:0]            ent_we,
  output logic [NUM_BP-1:0]            ent_xl
);
  import dab_pkg::*;

  typedef struct packed {
    logic [CMP_W-1:0] addr;
    logic             xl;
    logic             we;
    logic             re;
  } entry_t;

  logic unused_cfg_mid;
  if (GRAN > GRAN_MIN) begin : g_mid
    assign unused_cfg_mid = ^cfg_wdata[GRAN-1:GRAN_MIN];
  end else begin : g_nomid
    assign unused_cfg_mid = 1'b0;
  end

  entry_t wr_word;
  always_comb begin
    wr_word.addr = cfg_wdata[ADDR_W-1:GRAN];
    wr_word.xl   = cfg_wdata[FLD_XL];
    wr_word.we   = cfg_wdata[FLD_WE];
    wr_word.re   = cfg_wdata[FLD_RE];
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_ent
    entry_t ent_q;
    logic   sel_me;
    assign sel_me = cfg_we && (cfg_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= '0;
      end else if (sel_me) begin
        ent_q <= wr_word;
      end
    end

    assign ent_addr[i] = ent_q.addr;
    assign ent_re[i]   = ent_q.re;
    assign ent_we[i]   = ent_q.we;
    assign ent_xl[i]   = ent_q.xl;
  end
endmodule

// File: rtl/dab_match.sv
module dab_match #(
  parameter int CMP_W = 29
) (
  input  logic             acc_valid,
  input  logic [CMP_W-1:0] acc_dw,
  input  logic             acc_is_store,
  input  logic             acc_xlate,
  input  logic [CMP_W-1:0] ent_addr,
  input  logic             ent_re,
  input  logic             ent_we,
  input  logic             ent_xl,
  output logic             hit
);
  import dab_pkg::*;

  logic addr_eq;
  logic dir_ok;
  logic xl_ok;
  acc_kind_e kind;

  assign kind    = acc_kind_e'(acc_is_store);
  assign addr_eq = (acc_dw == ent_addr);
  assign xl_ok   = (acc_xlate == ent_xl);

  always_comb begin
    unique case (kind)
      ACC_STORE: dir_ok = ent_we;
      default:   dir_ok = ent_re;
    endcase
  end

  assign hit = acc_valid && addr_eq && dir_ok && xl_ok;
endmodule

// File: rtl/dab_flag_reg.sv
module dab_flag_reg #(
  parameter int NUM_BP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BP-1:0] hit_d,
  output logic              req_q,
  output logic [NUM_BP-1:0] hit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      hit_q <= '0;
    end else begin
      req_q <= |hit_d;
      hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/dab_detect.sv
module dab_detect #(
  parameter int ADDR_W = 32,
  parameter int GRAN   = 3,
  parameter int NUM_BP = 2,
  localparam int SEL_W = ($clog2(NUM_BP) > 0) ? $clog2(NUM_BP) : 1,
  localparam int CMP_W = ADDR_W - GRAN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_store,
  input  logic              acc_xlate,
  output logic              brk_req,
  output logic [NUM_BP-1:0] brk_hit
);
  logic [NUM_BP-1:0][CMP_W-1:0] ent_addr;
  logic [NUM_BP-1:0]            ent_re;
  logic [NUM_BP-1:0]            ent_we;
  logic [NUM_BP-1:0]            ent_xl;
  logic [NUM_BP-1:0]            hit_d;
  logic [CMP_W-1:0]             acc_dw;
  logic                         unused_low;

  assign acc_dw     = acc_addr[ADDR_W-1:GRAN];
  assign unused_low = ^acc_addr[GRAN-1:0];

  dab_bp_bank #(
    .ADDR_W(ADDR_W), .GRAN(GRAN), .NUM_BP(NUM_BP), .SEL_W(SEL_W)
  ) bank_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .ent_addr (ent_addr),
    .ent_re   (ent_re),
    .ent_we   (ent_we),
    .ent_xl   (ent_xl)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    dab_match #(.CMP_W(CMP_W)) match_i (
      .acc_valid   (acc_valid),
      .acc_dw      (acc_dw),
      .acc_is_store(acc_is_store),
      .acc_xlate   (acc_xlate),
      .ent_addr    (ent_addr[i]),
      .ent_re      (ent_re[i]),
      .ent_we      (ent_we[i]),
      .ent_xl      (ent_xl[i]),
      .hit         (hit_d[i])
    );
  end

  dab_flag_reg #(.NUM_BP(NUM_BP)) flags_i (
    .clk  (clk),
    .rst  (rst),
    .hit_d(hit_d),
    .req_q(brk_req),
    .hit_q(brk_hit)
  );
endmodule

// File: rtl/dab_detect_chk.sv
module dab_detect_chk #(
  parameter int NUM_BP = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_is_store,
  input logic              acc_xlate,
  input logic              brk_req,
  input logic [NUM_BP-1:0] brk_hit,
  input logic [NUM_BP-1:0] ent_re,
  input logic [NUM_BP-1:0] ent_we,
  input logic [NUM_BP-1:0] ent_xl
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!brk_req && brk_hit == '0));

  p_req_is_any_hit_r6: assert property (@(posedge clk) disable iff (rst)
    brk_req == (|brk_hit));

  p_idle_no_hit_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (brk_hit == '0));

  for (genvar i = 0; i < NUM_BP; i++) begin : g_ent
    p_load_needs_re_r3: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && !acc_is_store && !ent_re[i]) |=> !brk_hit[i]);

    p_store_needs_we_r4: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && acc_is_store && !ent_we[i]) |=> !brk_hit[i]);

    p_xlate_must_agree_r5: assert property (@(posedge clk) disable iff (rst)
      (acc_valid && (acc_xlate != ent_xl[i])) |=> !brk_hit[i]);
  end
endmodule

bind dab_detect dab_detect_chk #(.NUM_BP(NUM_BP)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_is_store(acc_is_store),
  .acc_xlate   (acc_xlate),
  .brk_req     (brk_req),
  .brk_hit     (brk_hit),
  .ent_re      (ent_re),
  .ent_we      (ent_we),
  .ent_xl      (ent_xl)
);

// File: tb/dab_detect_tb.sv
module dab_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_store = 1'b0;
  logic        acc_xlate = 1'b0;
  logic        brk_req;
  logic [1:0]  brk_hit;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dab_detect dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_is_store(acc_is_store), .acc_xlate(acc_xlate),
    .brk_req(brk_req), .brk_hit(brk_hit)
  );

  // Behavioural reference: entry words kept as plain integers.
  int unsigned m_ent[NB];
  logic [1:0]  exp_hit = '0;
  bit          model_live = 0;

  always @(posedge clk) begin
    logic [1:0] h;
    h = '0;
    if (rst) begin
      for (int i = 0; i < NB; i++) m_ent[i] = 0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        bit en;
        en = acc_is_store ? m_ent[i][1] : m_ent[i][0];
        if (acc_valid && en && (m_ent[i][2] == acc_xlate) &&
            ((m_ent[i] >> 3) == (acc_addr >> 3)))
          h[i] = 1'b1;
      end
      if (cfg_we) m_ent[cfg_sel] = cfg_wdata;
    end
    exp_hit = h;
    model_live = 1;
  end

  // Every-cycle comparison against the model (R6, R7).
  always @(negedge clk) begin
    if (model_live && !finished) begin
      checks++;
      if (brk_hit !== exp_hit || brk_req !== (|exp_hit)) begin
        errors++;
        $display("FAIL R7 model cycle: req=%b hit=%b expected req=%b hit=%b",
                 brk_req, brk_hit, |exp_hit, exp_hit);
      end
    end
  end

  task automatic chk(string tag, logic [1:0] exp_h);
    checks++;
    if (brk_hit !== exp_h || brk_req !== (|exp_h)) begin
      errors++;
      $display("FAIL %s: req=%b hit=%b expected req=%b hit=%b",
               tag, brk_req, brk_hit, |exp_h, exp_h);
    end
  endtask

  task automatic write_ent(int sel, logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'(sel); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(logic [31:0] a, bit st, bit xl, logic [1:0] exp_h, string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_is_store = st; acc_xlate = xl;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(tag, exp_h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs during reset", 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", 2'b00);
    probe(32'h0000_0000, 0, 0, 2'b00, "R1 zero entry load no hit");
    probe(32'h0000_0000, 1, 0, 2'b00, "R1 zero entry store no hit");

    // Entry 0: double-word 0x1000_0000, load enable, translation 0.
    write_ent(0, 32'h1000_0001);
    probe(32'h1000_0004, 0, 0, 2'b01, "R2 byte inside double-word");
    probe(32'h1000_0007, 0, 0, 2'b01, "R3 load with load enable");
    probe(32'h1000_0008, 0, 0, 2'b00, "R2 next double-word");
    probe(32'h1000_0000, 1, 0, 2'b00, "R4 store without store enable");
    probe(32'h1000_0000, 0, 1, 2'b00, "R5 translation mismatch");
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h1000_0000;
    @(negedge clk);
    chk("R7 strobe low no hit", 2'b00);

    // Entry 1: 0x2000_0000, store enable, translation 1.
    write_ent(1, 32'h2000_0006);
    probe(32'h2000_0003, 1, 1, 2'b10, "R4 store with store enable");
    probe(32'h2000_0000, 0, 1, 2'b00, "R3 load without load enable");
    probe(32'h2000_0000, 1, 0, 2'b00, "R5 store translation mismatch");
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 2'b00);

    // Both entries on the same double-word.
    write_ent(1, 32'h1000_0001);
    probe(32'h1000_0002, 0, 0, 2'b11, "R6 both entries hit");

    // Same-cycle rewrite: access uses old entry 0.
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h1000_0000; acc_is_store = 0; acc_xlate = 0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R8 same-cycle write uses old entry", 2'b11);
    probe(32'h1000_0000, 0, 0, 2'b10, "R8 later access sees new entry");

    // Random phase checked by the model every cycle.
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_sel = 1'($urandom_range(0, 1));
      cfg_wdata = {($urandom_range(0, 1) ? 29'h0200_0000 : 29'h0200_0001), 3'($urandom)};
      acc_valid = ($urandom_range(0, 3) != 0);
      acc_addr = {($urandom_range(0, 1) ? 29'h0200_0000 : 29'h0200_0001), 3'($urandom)};
      acc_is_store = 1'($urandom);
      acc_xlate = 1'($urandom);
      if (n == 1500) rst = 1'b1;
      if (n == 1503) rst = 1'b0;
    end
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule